// File: doc/BRIEF.md
# Keyboard Controller Output Buffer Arbiter

This block decides which waiting byte a keyboard controller shows to the host in its single output buffer. Four request lines compete for the buffer. Two come from the controller's own one-entry response slot: one for a reply tagged as keyboard-side and one for a reply tagged as auxiliary-side. The other two are the keyboard device queue and the auxiliary (pointing device) queue. Every source is a byte with a valid flag, and the source receives a pop pulse when its byte is consumed. Once a byte is presented, the selection stays frozen until the host reads the data port.

The block keeps the buffer-full and auxiliary-full status flags and copies them onto two output-port bits. It drives registered, level-sensitive keyboard and auxiliary interrupt lines from those flags and from the mode byte, which arrives as an input. An optional throttle, chosen by a parameter, holds off the next arbitration for a set number of clock cycles after a keyboard-sourced byte has been read.

Top module: `kbc_obuf_arbiter`

## Requirements
- R1: Fixed priority, highest first: keyboard-tagged response (`rsp_valid_i`=1, `rsp_is_aux_i`=0), auxiliary-tagged response (`rsp_valid_i`=1, `rsp_is_aux_i`=1), keyboard device byte, auxiliary device byte. The winner is presented at the first clock edge at which the buffer is empty and the throttle is idle.
- R2: Mode bit 4 set masks the keyboard device. Mode bit 5 set masks the auxiliary device. Responses are never masked. Clearing a mask bit lets pending data be presented at the next edge.
- R3: `stat_obf_o` is 1 while a byte is presented. `stat_aux_obf_o` is 1 while the presented byte is from an auxiliary-side source (auxiliary-tagged response or auxiliary device). `port_obf_o` and `port_aux_obf_o` always equal these two flags.
- R4: While the buffer is full and no read occurs, the selection never changes, even if a higher-priority source becomes valid.
- R5: `irq_kbd_o` is 1 exactly when the buffer is full, the auxiliary flag is clear, mode bit 0 is 1 and mode bit 4 is 0.
- R6: `irq_aux_o` is 1 exactly when the buffer is full, the auxiliary flag is set and mode bit 1 is 1.
- R7: A read (`rd_i`=1) while full pulses the pop output of the selected source only, in that same cycle. After the clock edge, `rd_data_o` holds the selected byte and both full flags are 0. A response pop is `rsp_pop_o` whatever the tag.
- R8: A read while empty pops nothing, and `rd_data_o` keeps the last byte read.
- R9: With the throttle enabled, reading a keyboard-device byte blocks any new selection for `THROTTLE_CYCLES` further edges, so the next byte appears `THROTTLE_CYCLES`+1 edges after the read edge. Reads from other sources do not start the throttle.
- R10: The interrupt lines are registered. They reflect a mode change one edge after the change, updated in the same edge as the full flags.
- R11: After reset every output is 0 and `rd_data_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_i | input | 8 | Current mode byte (bits 0,1,4,5 used) |
| rsp_valid_i | input | 1 | Response slot holds a byte |
| rsp_is_aux_i | input | 1 | Response tag: 0 keyboard-side, 1 auxiliary-side |
| rsp_data_i | input | 8 | Response byte |
| rsp_pop_o | output | 1 | Response consumed |
| kbd_valid_i | input | 1 | Keyboard queue has a byte |
| kbd_data_i | input | 8 | Keyboard queue head |
| kbd_pop_o | output | 1 | Keyboard byte consumed |
| aux_valid_i | input | 1 | Auxiliary queue has a byte |
| aux_data_i | input | 8 | Auxiliary queue head |
| aux_pop_o | output | 1 | Auxiliary byte consumed |
| rd_i | input | 1 | Host reads the data port this cycle |
| rd_data_o | output | 8 | Byte returned by the latest read |
| stat_obf_o | output | 1 | Status: output buffer full |
| stat_aux_obf_o | output | 1 | Status: auxiliary output buffer full |
| port_obf_o | output | 1 | Output-port copy of buffer full |
| port_aux_obf_o | output | 1 | Output-port copy of auxiliary full |
| irq_kbd_o | output | 1 | Keyboard interrupt level |
| irq_aux_o | output | 1 | Auxiliary interrupt level |

## Verification
Each test drives its inputs at a falling edge and samples one falling edge later. A newly valid source, a newly cleared mask and a mode change to the interrupt enables all show at that point, because the full flags and both interrupt lines are registered on the same edge. A read asserts `rd_i` at a falling edge. The pop pulse is sampled a moment later in that same cycle, and `rd_data_o` and the cleared flags are sampled at the next falling edge. After a keyboard-sourced read the bench samples once per cycle, expects the buffer to stay empty for `THROTTLE_CYCLES` samples, and expects it full at the following sample.

// File: rtl/kbc_obuf_pkg.sv
// Shared definitions for the output buffer arbiter.
// Source indices double as priority (0 = highest).
package kbc_obuf_pkg;

    localparam int NUM_SRC = 4;
    localparam int SRC_W   = $clog2(NUM_SRC);

    // Mode byte bit positions the arbiter decodes
    localparam int MODE_KBD_IRQ_EN = 0;
    localparam int MODE_AUX_IRQ_EN = 1;
    localparam int MODE_KBD_OFF    = 4;
    localparam int MODE_AUX_OFF    = 5;

    typedef enum logic [SRC_W-1:0] {
        SRC_RSP_KBD = 2'd0,
        SRC_RSP_AUX = 2'd1,
        SRC_DEV_KBD = 2'd2,
        SRC_DEV_AUX = 2'd3
    } src_e;

    // True for sources that raise the auxiliary-full flag
    function automatic logic is_aux_side(input src_e s);
        return (s == SRC_RSP_AUX) || (s == SRC_DEV_AUX);
    endfunction

endpackage

// File: rtl/kbc_obuf_select.sv
// Fixed-priority selector: lowest request index wins.
// Assumes requests are already masked by the caller. Purely combinational.
module kbc_obuf_select #(
    parameter int N   = 4,
    parameter int IDX = $clog2(N)
) (
    input  logic [N-1:0]   req_i,
    output logic           any_o,
    output logic [IDX-1:0] idx_o
);

    // Scan from lowest to highest priority so the highest one set wins last
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX'(i);
        end
    end

    assign any_o = |req_i;

endmodule

// File: rtl/kbc_obuf_throttle.sv
// Post-read hold-off timer. When enabled, a start pulse loads CYCLES
// and busy_o stays high until the count drains. When disabled it is
// never busy. Assumes start_i never arrives while busy.
module kbc_obuf_throttle #(
    parameter bit ENABLE = 1'b1,
    parameter int CYCLES = 100000,
    localparam int CNT_W = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);

    generate
        if (ENABLE) begin : g_timer
            logic [CNT_W-1:0] cnt_q;

            // Load on start, count down to zero otherwise
            always_ff @(posedge clk) begin
                if (!rst_n)              cnt_q <= '0;
                else if (start_i)        cnt_q <= CNT_W'(CYCLES);
                else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
            end

            assign busy_o = (cnt_q != '0);

            // R9: a keyboard read cannot occur while the hold-off runs
            p_no_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
                busy_o |-> !start_i);
        end else begin : g_none
            logic unused_start;
            assign unused_start = start_i;
            assign busy_o = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/kbc_obuf_irq.sv
// Registered interrupt level generator. Takes next-state full flags so
// the lines change on the same edge as the flags, using the mode bits
// present in the cycle before that edge.
module kbc_obuf_irq
    import kbc_obuf_pkg::*;
#(
    parameter int MODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              full_d_i,
    input  logic              aux_d_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic              irq_kbd_o,
    output logic              irq_aux_o
);

    // Register both interrupt levels
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_kbd_o <= 1'b0;
            irq_aux_o <= 1'b0;
        end else begin
            irq_kbd_o <= full_d_i && !aux_d_i && mode_i[MODE_KBD_IRQ_EN]
                         && !mode_i[MODE_KBD_OFF];
            irq_aux_o <= full_d_i && aux_d_i && mode_i[MODE_AUX_IRQ_EN];
        end
    end

endmodule

// File: rtl/kbc_obuf_arbiter.sv
// Output buffer arbiter for a keyboard controller. It picks one of four
// byte sources by fixed priority, holds the choice while the buffer is
// full, pops the source on a host data read, and drives the full flags and
// interrupt lines. Assumes each source holds its byte steady until popped.
module kbc_obuf_arbiter
    import kbc_obuf_pkg::*;
#(
    parameter int DATA_W          = 8,
    parameter int MODE_W          = 8,
    parameter bit THROTTLE_EN     = 1'b1,
    parameter int THROTTLE_CYCLES = 100000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_i,
    input  logic              rsp_valid_i,
    input  logic              rsp_is_aux_i,
    input  logic [DATA_W-1:0] rsp_data_i,
    output logic              rsp_pop_o,
    input  logic              kbd_valid_i,
    input  logic [DATA_W-1:0] kbd_data_i,
    output logic              kbd_pop_o,
    input  logic              aux_valid_i,
    input  logic [DATA_W-1:0] aux_data_i,
    output logic              aux_pop_o,
    input  logic              rd_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              stat_obf_o,
    output logic              stat_aux_obf_o,
    output logic              port_obf_o,
    output logic              port_aux_obf_o,
    output logic              irq_kbd_o,
    output logic              irq_aux_o
);

    logic [NUM_SRC-1:0] req;
    logic [DATA_W-1:0]  src_data [NUM_SRC];
    logic               grant_any;
    logic [SRC_W-1:0]   grant_idx;
    logic               thr_busy;
    logic               rd_hit;
    logic               can_arb;
    logic               full_q, full_d;
    logic               aux_q, aux_d;
    src_e               sel_q, sel_d;
    logic [DATA_W-1:0]  rd_q;
    logic               unused_mode;

    assign unused_mode = ^mode_i;

    // Build masked request vector in priority order
    always_comb begin
        req[SRC_RSP_KBD] = rsp_valid_i && !rsp_is_aux_i;
        req[SRC_RSP_AUX] = rsp_valid_i &&  rsp_is_aux_i;
        req[SRC_DEV_KBD] = kbd_valid_i && !mode_i[MODE_KBD_OFF];
        req[SRC_DEV_AUX] = aux_valid_i && !mode_i[MODE_AUX_OFF];
    end

    assign src_data[SRC_RSP_KBD] = rsp_data_i;
    assign src_data[SRC_RSP_AUX] = rsp_data_i;
    assign src_data[SRC_DEV_KBD] = kbd_data_i;
    assign src_data[SRC_DEV_AUX] = aux_data_i;

    kbc_obuf_select #(.N(NUM_SRC), .IDX(SRC_W)) u_select (
        .req_i (req),
        .any_o (grant_any),
        .idx_o (grant_idx)
    );

    assign rd_hit  = rd_i && full_q;
    assign can_arb = !full_q && !thr_busy;

    // Next-state for full flag, auxiliary flag and selection
    always_comb begin
        full_d = full_q;
        aux_d  = aux_q;
        sel_d  = sel_q;
        if (rd_hit) begin
            full_d = 1'b0;
            aux_d  = 1'b0;
        end else if (can_arb && grant_any) begin
            full_d = 1'b1;
            sel_d  = src_e'(grant_idx);
            aux_d  = is_aux_side(src_e'(grant_idx));
        end
    end

    // Buffer state registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= 1'b0;
            aux_q  <= 1'b0;
            sel_q  <= SRC_RSP_KBD;
        end else begin
            full_q <= full_d;
            aux_q  <= aux_d;
            sel_q  <= sel_d;
        end
    end

    // Capture the byte returned to the host
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_q <= '0;
        else if (rd_hit) rd_q <= src_data[sel_q];
    end

    // Pop pulses to the selected source
    always_comb begin
        rsp_pop_o = rd_hit && (sel_q == SRC_RSP_KBD || sel_q == SRC_RSP_AUX);
        kbd_pop_o = rd_hit && (sel_q == SRC_DEV_KBD);
        aux_pop_o = rd_hit && (sel_q == SRC_DEV_AUX);
    end

    kbc_obuf_throttle #(.ENABLE(THROTTLE_EN), .CYCLES(THROTTLE_CYCLES)) u_throttle (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (kbd_pop_o),
        .busy_o  (thr_busy)
    );

    kbc_obuf_irq #(.MODE_W(MODE_W)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .full_d_i  (full_d),
        .aux_d_i   (aux_d),
        .mode_i    (mode_i),
        .irq_kbd_o (irq_kbd_o),
        .irq_aux_o (irq_aux_o)
    );

    assign rd_data_o      = rd_q;
    assign stat_obf_o     = full_q;
    assign stat_aux_obf_o = aux_q;
    assign port_obf_o     = full_q;
    assign port_aux_obf_o = aux_q;

    // R7: at most one source popped per read
    p_one_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_pop_o, kbd_pop_o, aux_pop_o}));
    // R8: no pop while the buffer is empty
    p_no_pop_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_obf_o |-> !(rsp_pop_o || kbd_pop_o || aux_pop_o));
    // R4: selection frozen while full and unread
    p_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_obf_o && !rd_i) |=> (stat_obf_o && $stable(sel_q)));
    // R7: a read while full empties the buffer
    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_obf_o && rd_i) |=> !stat_obf_o);
    // R3: auxiliary flag only with the buffer full
    p_aux_in_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stat_aux_obf_o |-> stat_obf_o);
    // R5: keyboard interrupt only with a keyboard-side byte
    p_kbd_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_kbd_o |-> (stat_obf_o && !stat_aux_obf_o));
    // R6: auxiliary interrupt only with an auxiliary-side byte
    p_aux_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_aux_o |-> (stat_obf_o && stat_aux_obf_o));
    // R9: no new selection while the hold-off runs
    p_throttle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_busy && !stat_obf_o) |=> !stat_obf_o);
    // R2: a masked keyboard device is never newly selected
    p_kbd_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(stat_obf_o) && sel_q == SRC_DEV_KBD) |-> !$past(mode_i[MODE_KBD_OFF]));

endmodule

// File: tb/test_kbc_obuf_arbiter.sv
module test_kbc_obuf_arbiter;

    localparam int THR = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] mode = 8'h00;
    logic       rsp_v = 1'b0, rsp_a = 1'b0, kbd_v = 1'b0, aux_v = 1'b0, rd = 1'b0;
    logic [7:0] rsp_d = 8'h00, kbd_d = 8'h00, aux_d = 8'h00;
    logic       rsp_pop, kbd_pop, aux_pop;
    logic [7:0] rd_data;
    logic       obf, aobf, p_obf, p_aobf, irq_k, irq_a;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] last_byte = 8'h00;

    always #5 clk = ~clk;

    kbc_obuf_arbiter #(.THROTTLE_EN(1'b1), .THROTTLE_CYCLES(THR)) i_kbc_obuf_arbiter (
        .clk(clk), .rst_n(rst_n), .mode_i(mode),
        .rsp_valid_i(rsp_v), .rsp_is_aux_i(rsp_a), .rsp_data_i(rsp_d), .rsp_pop_o(rsp_pop),
        .kbd_valid_i(kbd_v), .kbd_data_i(kbd_d), .kbd_pop_o(kbd_pop),
        .aux_valid_i(aux_v), .aux_data_i(aux_d), .aux_pop_o(aux_pop),
        .rd_i(rd), .rd_data_o(rd_data),
        .stat_obf_o(obf), .stat_aux_obf_o(aobf), .port_obf_o(p_obf), .port_aux_obf_o(p_aobf),
        .irq_kbd_o(irq_k), .irq_aux_o(irq_a)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Check flags, mirrors and interrupts against an expected state
    task automatic chk_flags(input string tag, input bit e_full, input bit e_aux,
                             input bit e_ik, input bit e_ia);
        chk({tag, " R3 obf"}, obf, e_full);
        chk({tag, " R3 aux obf"}, aobf, e_aux);
        chk({tag, " R3 port mirror"}, {p_obf, p_aobf}, {e_full, e_aux});
        chk({tag, " R5 irq_kbd"}, irq_k, e_ik);
        chk({tag, " R6 irq_aux"}, irq_a, e_ia);
    endtask

    // Host read: pops sampled in the read cycle, data one edge later
    task automatic host_read(input string tag, input logic [2:0] e_pops, input logic [7:0] e_data);
        rd = 1'b1;
        #1;
        chk({tag, " R7 pops"}, {rsp_pop, kbd_pop, aux_pop}, e_pops);
        @(negedge clk);
        rd = 1'b0;
        chk({tag, " R7 read data"}, rd_data, e_data);
        chk({tag, " R7 cleared"}, {obf, aobf}, 2'b00);
        last_byte = e_data;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11 rd_data", rd_data, 0);
        chk_flags("R11", 0, 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_flags("R11 after release", 0, 0, 0, 0);

        // Sweep: response tag x device valids x mask bits (R1, R2, R3, R7, R8)
        for (int rs = 0; rs < 3; rs++) begin
            for (int k = 0; k < 2; k++) begin
                for (int a = 0; a < 2; a++) begin
                    for (int m = 0; m < 4; m++) begin
                        int w;
                        logic [7:0] e_data;
                        logic [2:0] e_pops;
                        bit ea;
                        mode  = {2'b00, m[1] ? 1'b1 : 1'b0, m[0] ? 1'b1 : 1'b0, 4'b0011};
                        rsp_v = (rs != 0);
                        rsp_a = (rs == 2);
                        rsp_d = 8'(8'h10 + rs * 16 + k * 4 + a * 2 + m);
                        kbd_d = 8'(8'h80 + rs * 16 + k * 4 + m);
                        aux_d = 8'(8'hC0 + rs * 16 + a * 4 + m);
                        kbd_v = k[0];
                        aux_v = a[0];
                        w = (rs == 1) ? 0 : (rs == 2) ? 1 :
                            (k == 1 && !m[0]) ? 2 : (a == 1 && !m[1]) ? 3 : 4;
                        ea = (w == 1 || w == 3);
                        @(negedge clk);
                        chk_flags("R1 sweep", w != 4, ea, (w == 0 || w == 2) && !m[0], ea);
                        case (w)
                            0, 1: begin e_data = rsp_d; e_pops = 3'b100; end
                            2:    begin e_data = kbd_d; e_pops = 3'b010; end
                            3:    begin e_data = aux_d; e_pops = 3'b001; end
                            default: begin e_data = last_byte; e_pops = 3'b000; end
                        endcase
                        host_read(w == 4 ? "R8 empty" : "R1 sweep", e_pops, e_data);
                        rsp_v = 1'b0; kbd_v = 1'b0; aux_v = 1'b0;
                        repeat ((w == 2) ? THR + 2 : 1) @(negedge clk);
                    end
                end
            end
        end

        // R4 freeze and R9 throttle timing
        mode  = 8'h03;
        kbd_d = 8'h5A; kbd_v = 1'b1;
        @(negedge clk);
        rsp_v = 1'b1; rsp_a = 1'b0; rsp_d = 8'hE1;
        repeat (3) @(negedge clk);
        chk_flags("R4 frozen", 1, 0, 1, 0);
        host_read("R4 kept kbd byte", 3'b010, 8'h5A);
        kbd_v = 1'b0;
        for (int j = 1; j <= THR; j++) begin
            @(negedge clk);
            chk("R9 held empty", obf, 0);
        end
        @(negedge clk);
        chk_flags("R9 released", 1, 0, 1, 0);
        host_read("R9 response after hold", 3'b100, 8'hE1);
        rsp_v = 1'b0;
        @(negedge clk);

        // R9: auxiliary read does not start the hold-off
        aux_v = 1'b1; aux_d = 8'h31;
        @(negedge clk);
        host_read("R9 aux read", 3'b001, 8'h31);
        aux_d = 8'h32;
        @(negedge clk);
        chk_flags("R9 no hold after aux", 1, 1, 0, 1);
        host_read("R9 second aux", 3'b001, 8'h32);
        aux_v = 1'b0;
        @(negedge clk);

        // R6/R10: auxiliary interrupt enable off, then on
        mode = 8'h00; aux_v = 1'b1; aux_d = 8'h44;
        @(negedge clk);
        chk_flags("R6 irq disabled", 1, 1, 0, 0);
        mode = 8'h02;
        @(negedge clk);
        chk_flags("R10 aux irq enabled", 1, 1, 0, 1);
        host_read("R7 aux", 3'b001, 8'h44);
        aux_v = 1'b0;
        @(negedge clk);

        // R5/R10: keyboard interrupt follows enable and disable bits
        mode = 8'h00; kbd_v = 1'b1; kbd_d = 8'h66;
        @(negedge clk);
        chk_flags("R5 irq disabled", 1, 0, 0, 0);
        mode = 8'h01;
        @(negedge clk);
        chk_flags("R10 kbd irq enabled", 1, 0, 1, 0);
        mode = 8'h11;
        @(negedge clk);
        chk_flags("R5 kbd off drops irq, byte kept", 1, 0, 0, 0);
        mode = 8'h01;
        @(negedge clk);
        host_read("R7 kbd", 3'b010, 8'h66);
        kbd_v = 1'b0;
        repeat (THR + 2) @(negedge clk);

        // R2/R10: masked keyboard data appears once unmasked
        mode = 8'h11; kbd_v = 1'b1; kbd_d = 8'h77;
        repeat (3) @(negedge clk);
        chk_flags("R2 masked stays empty", 0, 0, 0, 0);
        mode = 8'h01;
        @(negedge clk);
        chk_flags("R2 unmasked presented", 1, 0, 1, 0);
        host_read("R2 unmasked read", 3'b010, 8'h77);
        kbd_v = 1'b0;
        @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule